// File: doc/BRIEF.md
# Byte-Wide Parallel Port Register Slave

This block sits on the logic side of a byte-wide parallel host link. The host has an address strobe, a data strobe, a direction line, an 8-bit bus and a wait handshake. Each transfer moves one byte. An address cycle loads an internal address pointer. A data cycle stores the byte into a register array at that pointer, or returns the byte stored there, and then advances the pointer so that bursts fill or drain consecutive locations. Every completed data write adds one to a running counter. The host compares that counter with the number of bytes it sent.

The host control lines change with no relation to the local clock. The two strobes and the direction line are therefore passed through a two-flop synchronizer before any edge is detected. One host strobe then produces exactly one register update, and no write is lost or doubled. The block replies through a four-phase handshake. Wait rises once the byte has been taken in or the read byte is on the bus. Wait falls once the strobe is seen high again. The bus is split into an input, an output and an output enable, so the pad ring builds the tri-state driver.

Top module: `pport_reg_slave`

## Requirements
- R1: After reset, wait, output enable and the write counter are all zero, and an address read returns 0.
- R2: An address cycle with the direction line low (write) loads the bus byte into the address pointer. An address cycle with the direction line high (read) returns the pointer on the bus.
- R3: A data write cycle stores the bus byte at the pointer and then adds one to the pointer.
- R4: The write counter rises by exactly one for each data write cycle. Address cycles and read cycles leave it unchanged.
- R5: A data read cycle returns the byte stored at the pointer and then adds one to the pointer.
- R6: Wait goes high on the third rising clock edge after a strobe falls. It goes low on the third rising edge after both strobes are high again. It never rises while both strobes are seen high.
- R7: The output enable is high only while wait is high in a cycle with the direction line high. During write cycles it stays low.
- R8: A burst of 100 data writes from one start address reads back unchanged, and adds exactly 100 to the counter.
- R9: With the default 256-entry array, the pointer wraps from 255 to 0 after a data cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_astb_n | input | 1 | Host address strobe, active low, asynchronous |
| host_dstb_n | input | 1 | Host data strobe, active low, asynchronous |
| host_write_n | input | 1 | Direction line: low for a write, high for a read; rests high |
| bus_in | input | 8 | Byte arriving from the host bus |
| bus_out | output | 8 | Byte to drive onto the host bus |
| bus_oe | output | 1 | Enable for the bus driver |
| host_wait | output | 1 | Handshake reply to the host |
| wr_count | output | 16 | Number of completed data writes, wrapping |

## Verification
Every result of a transfer appears on the third rising edge after the strobe edge that causes it. Two edges go to the synchronizer and one to the handshake register. Wait, the output enable, the read byte and the counter all move on that edge, and wait falls on the third edge after the strobe returns high. The bench changes strobes on falling clock edges and samples one time unit after each rising edge. It confirms that wait is still low after the first and second edges and high after the third. Stored bytes and counter values are checked only after the handshake has closed.

// File: rtl/pport_pkg.sv
package pport_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic {
    PH_IDLE = 1'b0,
    PH_ACK  = 1'b1
  } phase_t;
endpackage

// File: rtl/pport_rst_sync.sv
module pport_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_o = chain_q[STAGES-1];
endmodule

// File: rtl/pport_sync.sv
module pport_sync #(
  parameter int           W        = 1,
  parameter int           STAGES   = 2,
  parameter logic [W-1:0] IDLE_VAL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage_q [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[g] <= IDLE_VAL;
        else        stage_q[g] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[g] <= IDLE_VAL;
        else        stage_q[g] <= stage_q[g-1];
      end
    end
  end

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/pport_regfile.sv
module pport_regfile #(
  parameter int DEPTH = 256,
  parameter int DW    = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cells[addr] <= wdata;
  end

  assign rdata = cells[addr];
endmodule

// File: rtl/pport_ctrl.sv
module pport_ctrl
  import pport_pkg::*;
#(
  parameter int DEPTH = 256,
  parameter int CNT_W = 16,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              astb_s,
  input  logic              dstb_s,
  input  logic              write_s,
  input  logic [BYTE_W-1:0] bus_in,
  input  logic [BYTE_W-1:0] mem_rdata,
  output logic              mem_we,
  output logic [AW-1:0]     addr,
  output logic [BYTE_W-1:0] rd_byte,
  output logic              ack,
  output logic              oe,
  output logic [CNT_W-1:0]  count
);
  phase_t              ph_q, ph_d;
  logic                astb_q, dstb_q;
  logic                a_fall, d_fall;
  logic                is_rd_q, is_rd_d;
  logic [AW-1:0]       addr_q, addr_d;
  logic [BYTE_W-1:0]   rd_q, rd_d;
  logic [BYTE_W-1:0]   addr_ext;
  logic [CNT_W-1:0]    cnt_q, cnt_d;

  assign a_fall = astb_q & ~astb_s;
  assign d_fall = dstb_q & ~dstb_s;

  always_comb begin
    addr_ext         = '0;
    addr_ext[AW-1:0] = addr_q;
  end

  always_comb begin
    ph_d    = ph_q;
    is_rd_d = is_rd_q;
    addr_d  = addr_q;
    rd_d    = rd_q;
    cnt_d   = cnt_q;
    mem_we  = 1'b0;
    unique case (ph_q)
      PH_IDLE: begin
        if (a_fall || d_fall) begin
          ph_d    = PH_ACK;
          is_rd_d = write_s;
          if (a_fall) begin
            if (!write_s) addr_d = bus_in[AW-1:0];
            else          rd_d   = addr_ext;
          end else begin
            addr_d = addr_q + AW'(1);
            if (!write_s) begin
              mem_we = 1'b1;
              cnt_d  = cnt_q + CNT_W'(1);
            end else begin
              rd_d = mem_rdata;
            end
          end
        end
      end
      PH_ACK: begin
        if (astb_s && dstb_s) ph_d = PH_IDLE;
      end
      default: ph_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q    <= PH_IDLE;
      astb_q  <= 1'b1;
      dstb_q  <= 1'b1;
      is_rd_q <= 1'b0;
      addr_q  <= '0;
      rd_q    <= '0;
      cnt_q   <= '0;
    end else begin
      ph_q    <= ph_d;
      astb_q  <= astb_s;
      dstb_q  <= dstb_s;
      is_rd_q <= is_rd_d;
      addr_q  <= addr_d;
      rd_q    <= rd_d;
      cnt_q   <= cnt_d;
    end
  end

  assign addr    = addr_q;
  assign rd_byte = rd_q;
  assign ack     = (ph_q == PH_ACK);
  assign oe      = (ph_q == PH_ACK) && is_rd_q;
  assign count   = cnt_q;
endmodule

// File: rtl/pport_reg_slave.sv
module pport_reg_slave
  import pport_pkg::*;
#(
  parameter int DEPTH       = 256,
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_astb_n,
  input  logic              host_dstb_n,
  input  logic              host_write_n,
  input  logic [BYTE_W-1:0] bus_in,
  output logic [BYTE_W-1:0] bus_out,
  output logic              bus_oe,
  output logic              host_wait,
  output logic [CNT_W-1:0]  wr_count
);
  localparam int AW = $clog2(DEPTH);

  logic              rst_n_s;
  logic [2:0]        ctl_s;
  logic              astb_s, dstb_s, write_s;
  logic              strobes_idle;
  logic              mem_we;
  logic [AW-1:0]     mem_addr;
  logic [BYTE_W-1:0] mem_rdata;

  pport_rst_sync #(.STAGES(2)) u_rst (
    .clk     (clk),
    .arst_n  (rst_n),
    .rst_n_o (rst_n_s)
  );

  pport_sync #(.W(3), .STAGES(SYNC_STAGES), .IDLE_VAL(3'b111)) u_sync (
    .clk   (clk),
    .rst_n (rst_n_s),
    .d     ({host_astb_n, host_dstb_n, host_write_n}),
    .q     (ctl_s)
  );

  assign {astb_s, dstb_s, write_s} = ctl_s;
  assign strobes_idle = astb_s & dstb_s;

  pport_ctrl #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .astb_s    (astb_s),
    .dstb_s    (dstb_s),
    .write_s   (write_s),
    .bus_in    (bus_in),
    .mem_rdata (mem_rdata),
    .mem_we    (mem_we),
    .addr      (mem_addr),
    .rd_byte   (bus_out),
    .ack       (host_wait),
    .oe        (bus_oe),
    .count     (wr_count)
  );

  pport_regfile #(.DEPTH(DEPTH), .DW(BYTE_W)) u_mem (
    .clk   (clk),
    .we    (mem_we),
    .addr  (mem_addr),
    .wdata (bus_in),
    .rdata (mem_rdata)
  );
endmodule

// File: rtl/pport_reg_slave_chk.sv
module pport_reg_slave_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             host_wait,
  input logic             bus_oe,
  input logic             strobes_idle,
  input logic [CNT_W-1:0] wr_count
);
  AST_WAIT_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    host_wait && strobes_idle |=> !host_wait); // R6
  AST_WAIT_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
    !host_wait && strobes_idle |=> !host_wait); // R6
  AST_OE_IN_HANDSHAKE: assert property (@(posedge clk) disable iff (!rst_n)
    bus_oe |-> host_wait); // R7
  AST_OE_STARTS_WITH_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_oe) |-> $rose(host_wait)); // R7
  AST_CNT_SINGLE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_count != $past(wr_count)) |-> (wr_count == $past(wr_count) + CNT_W'(1))); // R4
  AST_CNT_AT_HANDSHAKE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_count != $past(wr_count)) |-> $rose(host_wait)); // R4
endmodule

bind pport_reg_slave pport_reg_slave_chk #(.CNT_W(CNT_W)) chk_i (
  .clk          (clk),
  .rst_n        (rst_n_s),
  .host_wait    (host_wait),
  .bus_oe       (bus_oe),
  .strobes_idle (strobes_idle),
  .wr_count     (wr_count)
);

// File: tb/pport_reg_slave_tb_top.sv
`timescale 1ns/1ps
module pport_reg_slave_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        astb_n, dstb_n, write_n;
  logic [7:0]  bus_in;
  logic [7:0]  bus_out;
  logic        bus_oe, host_wait;
  logic [15:0] wr_count;

  int checks = 0;
  int errors = 0;
  bit done   = 0;
  logic [15:0] exp_cnt;
  logic [7:0]  img [100];

  always #10 clk = ~clk;

  pport_reg_slave dut_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .host_astb_n  (astb_n),
    .host_dstb_n  (dstb_n),
    .host_write_n (write_n),
    .bus_in       (bus_in),
    .bus_out      (bus_out),
    .bus_oe       (bus_oe),
    .host_wait    (host_wait),
    .wr_count     (wr_count)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic edge_sample();
    @(posedge clk);
    #1;
  endtask

  // One host cycle with exact handshake timing checks (R6, R7)
  task automatic xfer(input bit is_addr, input bit is_rd, input logic [7:0] wb,
                      output logic [7:0] rb);
    @(negedge clk);
    write_n = is_rd;
    bus_in  = wb;
    if (is_addr) astb_n = 1'b0; else dstb_n = 1'b0;
    edge_sample();
    edge_sample();
    check(host_wait == 1'b0, "R6 wait early", host_wait, 0);
    edge_sample();
    check(host_wait == 1'b1, "R6 wait on 3rd edge", host_wait, 1);
    check(bus_oe == is_rd, "R7 oe during handshake", bus_oe, is_rd);
    rb = bus_out;
    @(negedge clk);
    astb_n = 1'b1;
    dstb_n = 1'b1;
    edge_sample();
    edge_sample();
    check(host_wait == 1'b1, "R6 wait held", host_wait, 1);
    edge_sample();
    check(host_wait == 1'b0, "R6 wait release", host_wait, 0);
    check(bus_oe == 1'b0, "R7 oe off after handshake", bus_oe, 0);
    @(negedge clk);
    write_n = 1'b1;
  endtask

  // Quiet version for bursts: only checks results, not every edge
  task automatic xfer_q(input bit is_addr, input bit is_rd, input logic [7:0] wb,
                        output logic [7:0] rb);
    @(negedge clk);
    write_n = is_rd;
    bus_in  = wb;
    if (is_addr) astb_n = 1'b0; else dstb_n = 1'b0;
    repeat (3) edge_sample();
    rb = bus_out;
    @(negedge clk);
    astb_n = 1'b1;
    dstb_n = 1'b1;
    repeat (3) edge_sample();
    @(negedge clk);
    write_n = 1'b1;
  endtask

  task automatic t_reset();
    logic [7:0] r;
    check(host_wait == 1'b0, "R1 wait after reset", host_wait, 0);
    check(bus_oe == 1'b0, "R1 oe after reset", bus_oe, 0);
    check(wr_count == 16'd0, "R1 count after reset", wr_count, 0);
    xfer(1, 1, 8'h00, r);
    check(r == 8'h00, "R1 address after reset", r, 0);
  endtask

  task automatic t_addr();
    logic [7:0] r;
    xfer(1, 0, 8'h5A, r);
    xfer(1, 1, 8'h00, r);
    check(r == 8'h5A, "R2 address readback", r, 8'h5A);
    check(wr_count == exp_cnt, "R4 address cycles do not count", wr_count, exp_cnt);
  endtask

  task automatic t_data_single();
    logic [7:0] r;
    xfer(1, 0, 8'h20, r);
    xfer(0, 0, 8'hC3, r);
    exp_cnt++;
    check(wr_count == exp_cnt, "R4 one write one count", wr_count, exp_cnt);
    xfer(1, 1, 8'h00, r);
    check(r == 8'h21, "R3 pointer advanced after write", r, 8'h21);
    xfer(1, 0, 8'h20, r);
    xfer(0, 1, 8'h00, r);
    check(r == 8'hC3, "R5 read returns stored byte", r, 8'hC3);
    xfer(1, 1, 8'h00, r);
    check(r == 8'h21, "R5 pointer advanced after read", r, 8'h21);
    check(wr_count == exp_cnt, "R4 reads do not count", wr_count, exp_cnt);
  endtask

  task automatic t_burst();
    logic [7:0] r;
    int bad = 0;
    for (int i = 0; i < 100; i++) img[i] = 8'((i * 37 + 11) ^ (i >> 2));
    xfer_q(1, 0, 8'h40, r);
    for (int i = 0; i < 100; i++) xfer_q(0, 0, img[i], r);
    exp_cnt += 16'd100;
    check(wr_count == exp_cnt, "R8 burst count", wr_count, exp_cnt);
    xfer_q(1, 0, 8'h40, r);
    for (int i = 0; i < 100; i++) begin
      xfer_q(0, 1, 8'h00, r);
      if (r !== img[i]) begin
        bad++;
        check(0, "R8 burst byte", r, img[i]);
      end
    end
    check(bad == 0, "R8 burst intact", bad, 0);
  endtask

  task automatic t_wrap();
    logic [7:0] r;
    xfer(1, 0, 8'hFF, r);
    xfer(0, 0, 8'h77, r);
    exp_cnt++;
    xfer(0, 0, 8'h88, r);
    exp_cnt++;
    xfer(1, 1, 8'h00, r);
    check(r == 8'h01, "R9 pointer wrapped", r, 8'h01);
    xfer(1, 0, 8'h00, r);
    xfer(0, 1, 8'h00, r);
    check(r == 8'h88, "R9 byte after wrap at 0", r, 8'h88);
    xfer(1, 0, 8'hFF, r);
    xfer(0, 1, 8'h00, r);
    check(r == 8'h77, "R9 byte at top", r, 8'h77);
    check(wr_count == exp_cnt, "R4 count after wrap", wr_count, exp_cnt);
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n   = 1'b0;
    astb_n  = 1'b1;
    dstb_n  = 1'b1;
    write_n = 1'b1;
    bus_in  = 8'h00;
    exp_cnt = 16'd0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_reset();
    t_addr();
    t_data_single();
    t_burst();
    t_wrap();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule